// File: doc/BRIEF.md
# PWM Dead-Band Generator

This block sits after a PWM compare stage and turns two raw PWM levels, A and B, into two gated outputs. Each output edge can be held back by a programmable number of time-base clock cycles. The usual use is a complementary pair for a half bridge. One output follows the source with a delayed rising edge. The other output is the inverted source with a delayed falling edge. This gives a dead time in which neither switch is driven.

There are two delay paths: a rising-edge path and a falling-edge path. Each path is a three-state machine, and each has its own source select and its own polarity switch. A routing switch chooses whether each output gets one delay, or whether output A gets both delays in series. Per-output enables choose between the delayed signal and the registered raw input. A final swap stage can exchange or duplicate the two channels. A simple synchronous write port loads one switch word and the two delay counts.

The delay path machine has three states, `DU_IDLE`, `DU_COUNT` and `DU_HELD`:
- `DU_IDLE` goes to `DU_HELD` when the watched level is seen and the count is zero.
- `DU_IDLE` goes to `DU_COUNT` when the watched level is seen and the count is non-zero.
- `DU_COUNT` goes to `DU_HELD` once the level has lasted long enough.
- `DU_COUNT` goes back to `DU_IDLE` when the level drops.
- `DU_HELD` goes back to `DU_IDLE` when the level drops.

The path is asserted only in `DU_HELD`. Each state is held by default.

Top module: `deadband_gen`

## Requirements
- R1: While reset is low and after it, all switch bits and both counts are zero. Both outputs then show the raw inputs one clock late: a level sampled at an edge appears just after that edge.
- R2: A write with `cfg_we` high loads the selected register at the next edge, and the new value is in use from the following edge. Address 0 is the switch word, address 1 is the rising count (all 14 bits), and address 2 is the falling count. A write to address 3 changes nothing.
- R3: The rising path goes high only after its source has been high for N+1 consecutive samples, where N is the rising count. A high pulse of N samples or fewer never appears. The rising path falls one clock after the source falls.
- R4: The falling path stays high until its source has been low for N+1 consecutive samples, where N is the falling count. This is applied before any inversion. A count of zero gives plain one-clock latency.
- R5: Switch bit 4 selects the rising path source and bit 5 selects the falling path source. For each, 0 means input A and 1 means input B.
- R6: Switch bit 2 inverts the rising path result and bit 3 inverts the falling path result. Setting bits 0, 1 and 3 with equal counts gives an active-high complementary pair.
- R7: Switch bit 6 set feeds the falling path from the rising path result, and routes this two-delay signal to channel A while channel B carries the rising path. With bit 6 clear, channel A carries the rising path and channel B carries the falling path.
- R8: Switch bit 0 makes channel A use its delayed signal instead of registered input A. Bit 1 does the same for channel B.
- R9: Switch bit 7 set drives output A from channel B. Switch bit 8 set drives output B from channel A. With both clear, the channels pass straight through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Register select: 0 switches, 1 rising count, 2 falling count |
| cfg_wdata | input | 14 | Write data |
| pwm_a_in | input | 1 | Raw PWM level A |
| pwm_b_in | input | 1 | Raw PWM level B |
| pwm_a_out | output | 1 | Gated output A |
| pwm_b_out | output | 1 | Gated output B |

## Verification
A path machine stuck in `DU_COUNT`, or a counter off by one, shows up at the next delayed edge. That edge arrives one cycle early or late compared with the bench model, or a short pulse leaks through. This is visible within N+2 cycles of the source edge. A wrong switch word or a wrong load timing makes an output follow the wrong source, polarity or channel. That mismatch is seen on the first cycle where the two candidate signals differ. The random phases make such differences frequent.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

    typedef enum logic [1:0] {
        DU_IDLE,
        DU_COUNT,
        DU_HELD
    } du_state_e;

    // Switch word, bit 0 at the bottom.
    typedef struct packed {
        logic swap_b;    // 8
        logic swap_a;    // 7
        logic dual_a;    // 6
        logic src_fall;  // 5
        logic src_rise;  // 4
        logic inv_fall;  // 3
        logic inv_rise;  // 2
        logic dly_b;     // 1
        logic dly_a;     // 0
    } sw_t;

    localparam int SW_W = $bits(sw_t);

endpackage

// File: rtl/dbg_delay_unit.sv
module dbg_delay_unit
    import dbg_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_lvl,
    input  logic [CNT_W-1:0] dly_cnt,
    output logic             held
);

    du_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DU_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            DU_IDLE: begin
                if (hold_lvl) begin
                    if (dly_cnt == '0) begin
                        state_d = DU_HELD;
                    end else begin
                        state_d = DU_COUNT;
                        cnt_d   = CNT_W'(1);
                    end
                end
            end
            DU_COUNT: begin
                if (!hold_lvl) begin
                    state_d = DU_IDLE;
                    cnt_d   = '0;
                end else if (cnt_q >= dly_cnt) begin
                    state_d = DU_HELD;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            DU_HELD: begin
                if (!hold_lvl) begin
                    state_d = DU_IDLE;
                end
            end
            default: begin
                state_d = DU_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // Output
    always_comb begin
        held = (state_q == DU_HELD);
    end

endmodule

// File: rtl/dbg_cfg_regs.sv
module dbg_cfg_regs
    import dbg_pkg::*;
#(
    parameter int CNT_W  = 14,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output sw_t               sw,
    output logic [CNT_W-1:0]  rise_cnt,
    output logic [CNT_W-1:0]  fall_cnt
);

    localparam logic [ADDR_W-1:0] ADR_SW   = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADR_RISE = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] ADR_FALL = ADDR_W'(2);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw       <= '0;
            rise_cnt <= '0;
            fall_cnt <= '0;
        end else if (we) begin
            if (addr == ADR_SW) begin
                sw <= sw_t'(wdata[SW_W-1:0]);
            end else if (addr == ADR_RISE) begin
                rise_cnt <= wdata;
            end else if (addr == ADR_FALL) begin
                fall_cnt <= wdata;
            end
        end
    end

endmodule

// File: rtl/dbg_route.sv
module dbg_route
    import dbg_pkg::*;
(
    input  sw_t  sw,
    input  logic rise_on,
    input  logic fall_held,
    input  logic a_q,
    input  logic b_q,
    output logic out_a,
    output logic out_b
);

    logic rise_path, fall_path, dly_a, dly_b, ch_a, ch_b;

    always_comb begin
        rise_path = rise_on ^ sw.inv_rise;
        fall_path = ~fall_held ^ sw.inv_fall;
        dly_a     = sw.dual_a ? fall_path : rise_path;
        dly_b     = sw.dual_a ? rise_path : fall_path;
        ch_a      = sw.dly_a ? dly_a : a_q;
        ch_b      = sw.dly_b ? dly_b : b_q;
        out_a     = sw.swap_a ? ch_b : ch_a;
        out_b     = sw.swap_b ? ch_a : ch_b;
    end

endmodule

// File: rtl/deadband_gen.sv
module deadband_gen
    import dbg_pkg::*;
#(
    parameter int CNT_W  = 14,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CNT_W-1:0]  cfg_wdata,
    input  logic              pwm_a_in,
    input  logic              pwm_b_in,
    output logic              pwm_a_out,
    output logic              pwm_b_out
);

    localparam int N_PATH = 2;

    sw_t              sw_q;
    logic [CNT_W-1:0] rise_cnt_q, fall_cnt_q;
    logic             a_q, b_q;
    logic             rise_src, fall_src, rise_on, fall_held;
    logic [N_PATH-1:0] path_lvl, path_held;
    logic [CNT_W-1:0]  path_cnt [N_PATH];

    dbg_cfg_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .sw       (sw_q),
        .rise_cnt (rise_cnt_q),
        .fall_cnt (fall_cnt_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= 1'b0;
            b_q <= 1'b0;
        end else begin
            a_q <= pwm_a_in;
            b_q <= pwm_b_in;
        end
    end

    always_comb begin
        rise_src    = sw_q.src_rise ? pwm_b_in : pwm_a_in;
        fall_src    = sw_q.dual_a ? rise_on : (sw_q.src_fall ? pwm_b_in : pwm_a_in);
        path_lvl[0] = rise_src;
        path_lvl[1] = ~fall_src;
        path_cnt[0] = rise_cnt_q;
        path_cnt[1] = fall_cnt_q;
        rise_on     = path_held[0];
        fall_held   = path_held[1];
    end

    for (genvar p = 0; p < N_PATH; p++) begin : g_path
        dbg_delay_unit #(.CNT_W(CNT_W)) u_du (
            .clk      (clk),
            .rst_n    (rst_n),
            .hold_lvl (path_lvl[p]),
            .dly_cnt  (path_cnt[p]),
            .held     (path_held[p])
        );
    end

    dbg_route u_route (
        .sw        (sw_q),
        .rise_on   (rise_on),
        .fall_held (fall_held),
        .a_q       (a_q),
        .b_q       (b_q),
        .out_a     (pwm_a_out),
        .out_b     (pwm_b_out)
    );

endmodule

// File: rtl/deadband_gen_chk.sv
module deadband_gen_chk #(
    parameter int CNT_W = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [1:0]       cfg_addr,
    input logic [CNT_W-1:0] cfg_wdata,
    input logic             pwm_a_in,
    input logic             pwm_b_in,
    input logic             pwm_a_out,
    input logic             pwm_b_out,
    input logic             dly_a,
    input logic             dly_b,
    input logic             swap_a,
    input logic             swap_b,
    input logic [CNT_W-1:0] rise_cnt,
    input logic [CNT_W-1:0] fall_cnt,
    input logic             rise_src,
    input logic             fall_src,
    input logic             rise_on,
    input logic             fall_held
);

    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    a_r2_rise_load: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(cfg_we && cfg_addr == 2'd1) |-> rise_cnt == $past(cfg_wdata));

    a_r2_fall_load: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(cfg_we && cfg_addr == 2'd2) |-> fall_cnt == $past(cfg_wdata));

    a_r3_rise_needs_high: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && rise_on |-> $past(rise_src));

    a_r3_zero_rise: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(rise_cnt == '0) |-> rise_on == $past(rise_src));

    a_r4_fall_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && fall_held |-> !$past(fall_src));

    a_r4_zero_fall: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(fall_cnt == '0) |-> fall_held == !$past(fall_src));

    a_r8_bypass_a: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !dly_a && !swap_a |-> pwm_a_out == $past(pwm_a_in));

    a_r8_bypass_b: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !dly_b && !swap_b |-> pwm_b_out == $past(pwm_b_in));

endmodule

bind deadband_gen deadband_gen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .pwm_a_in  (pwm_a_in),
    .pwm_b_in  (pwm_b_in),
    .pwm_a_out (pwm_a_out),
    .pwm_b_out (pwm_b_out),
    .dly_a     (sw_q.dly_a),
    .dly_b     (sw_q.dly_b),
    .swap_a    (sw_q.swap_a),
    .swap_b    (sw_q.swap_b),
    .rise_cnt  (rise_cnt_q),
    .fall_cnt  (fall_cnt_q),
    .rise_src  (rise_src),
    .fall_src  (fall_src),
    .rise_on   (rise_on),
    .fall_held (fall_held)
);

// File: tb/test_deadband_gen.sv
module test_deadband_gen;

    localparam int CNT_W = 14;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [1:0]       cfg_addr = '0;
    logic [CNT_W-1:0] cfg_wdata = '0;
    logic             pwm_a_in = 1'b0;
    logic             pwm_b_in = 1'b0;
    logic             pwm_a_out, pwm_b_out;

    always #5 clk = ~clk;

    deadband_gen #(.CNT_W(CNT_W), .ADDR_W(2)) i_deadband_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .pwm_a_in  (pwm_a_in),
        .pwm_b_in  (pwm_b_in),
        .pwm_a_out (pwm_a_out),
        .pwm_b_out (pwm_b_out)
    );

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;
    string tag    = "R1";
    bit    cur_a  = 1'b0;
    bit    cur_b  = 1'b0;

    // Reference model state
    logic [8:0] m_sw = '0;
    int  m_nr = 0, m_nf = 0;
    int  m_rrun = 0, m_frun = 0;
    bit  m_ract = 1'b0, m_fact = 1'b0;
    bit  m_aq = 1'b0, m_bq = 1'b0;

    always @(posedge clk) begin : model
        bit sr, sf;
        if (!rst_n) begin
            m_sw = '0; m_nr = 0; m_nf = 0;
            m_rrun = 0; m_frun = 0; m_ract = 0; m_fact = 0;
            m_aq = 0; m_bq = 0;
        end else begin
            sr = m_sw[4] ? pwm_b_in : pwm_a_in;
            sf = m_sw[6] ? m_ract : (m_sw[5] ? pwm_b_in : pwm_a_in);
            if (sr) begin
                if (m_rrun < 30000) m_rrun++;
                m_ract = m_ract || (m_rrun >= m_nr + 1);
            end else begin
                m_rrun = 0; m_ract = 0;
            end
            if (!sf) begin
                if (m_frun < 30000) m_frun++;
                m_fact = m_fact || (m_frun >= m_nf + 1);
            end else begin
                m_frun = 0; m_fact = 0;
            end
            m_aq = pwm_a_in;
            m_bq = pwm_b_in;
            if (cfg_we) begin
                case (cfg_addr)
                    2'd0: m_sw = cfg_wdata[8:0];
                    2'd1: m_nr = int'(cfg_wdata);
                    2'd2: m_nf = int'(cfg_wdata);
                    default: ;
                endcase
            end
        end
    end

    function automatic bit exp_out(input bit side_b);
        bit rp, fp, da, db, ca, cb;
        rp = m_ract ^ m_sw[2];
        fp = (~m_fact) ^ m_sw[3];
        da = m_sw[6] ? fp : rp;
        db = m_sw[6] ? rp : fp;
        ca = m_sw[0] ? da : m_aq;
        cb = m_sw[1] ? db : m_bq;
        if (side_b) return m_sw[8] ? ca : cb;
        return m_sw[7] ? cb : ca;
    endfunction

    task automatic chk(input logic act, input bit exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual %b expected %b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic cyc(input bit na, input bit nb, input bit we = 1'b0,
                       input logic [1:0] ad = 2'd0, input logic [CNT_W-1:0] d = '0);
        @(negedge clk);
        chk(pwm_a_out, exp_out(1'b0), "pwm_a_out");
        chk(pwm_b_out, exp_out(1'b1), "pwm_b_out");
        pwm_a_in  = na;
        pwm_b_in  = nb;
        cfg_we    = we;
        cfg_addr  = ad;
        cfg_wdata = d;
        cur_a = na;
        cur_b = nb;
    endtask

    task automatic setup(input string t, input logic [8:0] sw, input int nr, input int nf);
        tag = t;
        cyc(cur_a, cur_b, 1'b1, 2'd0, CNT_W'(sw));
        cyc(cur_a, cur_b, 1'b1, 2'd1, CNT_W'(nr));
        cyc(cur_a, cur_b, 1'b1, 2'd2, CNT_W'(nf));
    endtask

    task automatic wander(input int n, input bit cfg_noise);
        for (int i = 0; i < n; i++) begin
            bit na, nb;
            na = cur_a; nb = cur_b;
            if ($urandom_range(0, 3) == 0) na = ~na;
            if ($urandom_range(0, 3) == 0) nb = ~nb;
            if (cfg_noise && $urandom_range(0, 7) == 0) begin
                logic [1:0] ad;
                logic [CNT_W-1:0] d;
                ad = 2'($urandom_range(0, 3));
                d  = (ad == 2'd1 || ad == 2'd2) ? CNT_W'($urandom_range(0, 9)) : CNT_W'($urandom);
                cyc(na, nb, 1'b1, ad, d);
            end else begin
                cyc(na, nb);
            end
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R1 actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd24681));
        // R1: reset state, outputs low with bypass
        tag = "R1 reset";
        repeat (3) cyc(1'b1, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        tag = "R1 bypass latency";
        cyc(1'b1, 1'b0);
        cyc(1'b0, 1'b1);
        cyc(1'b1, 1'b1);
        cyc(1'b0, 1'b0);
        wander(40, 1'b0);

        // R3: short pulse absorbed, long pulse passes late
        setup("R3 short pulse", 9'h003, 3, 0);
        repeat (4) cyc(1'b0, 1'b0);
        repeat (3) cyc(1'b1, 1'b0);
        repeat (6) cyc(1'b0, 1'b0);
        repeat (8) cyc(1'b1, 1'b0);
        repeat (4) cyc(1'b0, 1'b0);
        setup("R3 rising delay", 9'h003, 4, 0);
        wander(300, 1'b0);

        // R4: falling delay and zero counts
        setup("R4 falling delay", 9'h003, 0, 6);
        wander(300, 1'b0);
        setup("R4 zero delays", 9'h003, 0, 0);
        wander(200, 1'b0);

        // R6: active-high complementary pair
        setup("R6 complementary", 9'h00B, 5, 5);
        wander(300, 1'b0);
        setup("R6 both inverted", 9'h00F, 2, 3);
        wander(200, 1'b0);

        // R5: source selection
        setup("R5 rise from B", 9'h013, 3, 2);
        wander(250, 1'b0);
        setup("R5 fall from B", 9'h023, 2, 4);
        wander(250, 1'b0);

        // R7: both delays on channel A
        setup("R7 dual edge", 9'h04B, 3, 2);
        wander(300, 1'b0);

        // R8: per-output bypass
        setup("R8 A delayed B raw", 9'h001, 3, 3);
        wander(200, 1'b0);
        setup("R8 B delayed A raw", 9'h00A, 3, 3);
        wander(200, 1'b0);

        // R9: swap stage
        setup("R9 swap both", 9'h18B, 4, 1);
        wander(200, 1'b0);
        setup("R9 A from B only", 9'h08B, 2, 2);
        wander(200, 1'b0);

        // R2: address 3 ignored, then random writes mid-run
        setup("R2 addr3 ignored", 9'h00B, 3, 3);
        cyc(cur_a, cur_b, 1'b1, 2'd3, '1);
        wander(60, 1'b0);
        tag = "R2 random writes";
        wander(1500, 1'b1);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule